// File: doc/BRIEF.md
# Serial Frame Check Sequence Generator and Checker

This block computes a 16-bit frame check sequence for a bit-serial synchronous link. Its transmit half folds every outgoing data bit into a CRC register and, on request, shifts the finished check word out on the line bit after the data. Its receive half folds every incoming bit, including the received check word, into a second CRC register. An end-of-frame strobe then compares that register with the value an intact frame leaves, and the block raises a pass flag. A single bit-enable strobe paces both halves, one bit per strobe.

The configuration inputs are live levels. One picks the preset, all ones or all zeros. One picks the generator polynomial. A third selects the inverted-check convention, in which the transmitted check word is complemented and the receiver expects a fixed non-zero residue. A separate start-of-frame pulse reloads the preset on each side. While the channel is not in synchronous mode, both halves freeze. Flag generation, zero-bit stuffing and frame delimiting are handled outside this block.

Top module: `hdlc_fcs_unit`

## Requirements
- R1: A synchronous reset clears both CRC registers to all zeros, clears `rx_crc_ok` and `tx_fcs_busy`, and makes the preset behave as all-zeros until the next start-of-frame pulse. A check word requested straight after reset is 0x0000, and an end strobe straight after reset with `sdlc_mode`=0 passes.
- R2: A start-of-frame pulse (`tx_sof`/`rx_sof`) loads that side's register with 0xFFFF when `preset_ones`=1 and with 0x0000 when it is 0. This works with either polynomial.
- R3: With `poly_sel`=0 the generator polynomial is x^16+x^12+x^5+1. Bits enter least significant bit first. Over the bytes 0x31..0x39 with the all-ones preset, the register ends at 0x6F91.
- R4: With `poly_sel`=1 the generator polynomial is x^16+x^15+x^2+1. Over the bytes 0x31..0x39 with the all-zeros preset, the register ends at 0xBB3D.
- R5: A `fcs_send` pulse raises `tx_fcs_busy` on the next clock. While it is high, `tx_line` carries register bit 0 and each `bit_en` shifts the next bit down, so bit 0 goes out first. After the 16th strobe, `tx_fcs_busy` falls. Outside that window, `tx_line` follows `tx_bit`.
- R6: With `sdlc_mode`=1 every transmitted check bit is complemented. With `sdlc_mode`=0 it is sent as held.
- R7: With `sdlc_mode`=0 a frame passes when the receive register is all zeros at the end strobe.
- R8: With `sdlc_mode`=1 a frame passes when the receive register, read from bit 0 upward, is 0001110100001111 (value 0xF0B8) for `poly_sel`=0. For `poly_sel`=1 it must equal the register left by sixteen one-bits from zero. A corrupted frame fails.
- R9: `rx_crc_ok` is updated only by `rx_eof`, one clock later, using the register value before any bit taken in that same cycle. It holds until `rx_sof` clears it.
- R10: Cycles with `bit_en` low change neither register, whatever the data inputs do.
- R11: While `sync_mode`=0 both registers, `tx_fcs_busy` and `rx_crc_ok` hold. `fcs_send`, both start pulses and `rx_eof` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode | input | 1 | 1 = synchronous channel, CRC active; 0 = block idle |
| sdlc_mode | input | 1 | 1 = inverted check word and fixed residue |
| preset_ones | input | 1 | 1 = preset 0xFFFF, 0 = preset 0x0000 |
| poly_sel | input | 1 | 0 = x^16+x^12+x^5+1, 1 = x^16+x^15+x^2+1 |
| bit_en | input | 1 | One strobe per serial bit, shared by both halves |
| tx_sof | input | 1 | Reload transmit register with preset |
| tx_bit | input | 1 | Outgoing data bit |
| fcs_send | input | 1 | Start shifting out the check word |
| tx_line | output | 1 | Serial line bit: data, or check bit while busy |
| tx_fcs_busy | output | 1 | Check word is being shifted out |
| rx_sof | input | 1 | Reload receive register with preset, clear pass flag |
| rx_bit | input | 1 | Incoming bit (data and check word) |
| rx_eof | input | 1 | End-of-frame strobe, evaluate pass flag |
| rx_crc_ok | output | 1 | Frame passed the check |

## Verification
`tx_line` is combinational from the register and the input bit. It is read after each falling edge, before the `bit_en` edge that shifts it. `tx_fcs_busy` is due one clock after `fcs_send`. It must fall right after the 16th shift edge, and the bench reads it at the next falling edge. `rx_crc_ok` is due one clock after `rx_eof` or `rx_sof`. Inputs are always changed and outputs read at falling edges, so each result is sampled half a cycle after the rising edge that produces it.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int CRC_W = 16;
    localparam int CNT_W = $clog2(CRC_W);

    typedef logic [CRC_W-1:0] crc_t;

    // bit-reversed masks for right-shifting, LSB-first registers
    localparam crc_t MASK_CCITT = 16'h8408;  // x^16+x^12+x^5+1
    localparam crc_t MASK_ANSI  = 16'hA001;  // x^16+x^15+x^2+1

    typedef enum logic {
        POLY_CCITT = 1'b0,
        POLY_ANSI  = 1'b1
    } poly_e;

    typedef struct packed {
        logic  sdlc;
        logic  preset_ones;
        poly_e poly;
    } fcs_cfg_t;

    function automatic crc_t poly_mask(poly_e p);
        return (p == POLY_ANSI) ? MASK_ANSI : MASK_CCITT;
    endfunction

    function automatic crc_t crc_step(crc_t c, logic d, poly_e p);
        crc_t nxt;
        nxt = c >> 1;
        if (c[0] ^ d)
            nxt = nxt ^ poly_mask(p);
        return nxt;
    endfunction

    function automatic crc_t preset_val(logic ones);
        return ones ? '1 : '0;
    endfunction

    // register left by an intact frame; with an inverted check word this is
    // the register produced by all-ones bits fed from zero
    function automatic crc_t good_residue(fcs_cfg_t cfg);
        crc_t r;
        r = '0;
        if (cfg.sdlc) begin
            for (int i = 0; i < CRC_W; i++)
                r = crc_step(r, 1'b1, cfg.poly);
        end
        return r;
    endfunction

endpackage

// File: rtl/fcs_tx.sv
module fcs_tx
    import fcs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en_sync,
    input  logic     bit_en,
    input  logic     sof,
    input  fcs_cfg_t cfg,
    input  logic     data_bit,
    input  logic     fcs_go,
    output logic     line_bit,
    output logic     fcs_busy
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CRC_W - 1);

    crc_t             crc_q;
    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q  <= '0;
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (en_sync) begin
            if (sof) begin
                crc_q  <= preset_val(cfg.preset_ones);
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else if (busy_q) begin
                if (bit_en) begin
                    crc_q <= crc_q >> 1;
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST_IDX)
                        busy_q <= 1'b0;
                end
            end else if (fcs_go) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end else if (bit_en) begin
                crc_q <= crc_step(crc_q, data_bit, cfg.poly);
            end
        end
    end

    assign line_bit = busy_q ? (crc_q[0] ^ cfg.sdlc) : data_bit;
    assign fcs_busy = busy_q;

    AST_TX_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(fcs_go && en_sync)); // R5
    AST_TX_BUSY_END: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> $past(bit_en || sof)); // R5
    AST_TX_NO_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!bit_en && !sof) |=> $stable(crc_q)); // R10
    AST_TX_ASYNC_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en_sync |=> ($stable(crc_q) && $stable(busy_q))); // R11

endmodule

// File: rtl/fcs_rx.sv
module fcs_rx
    import fcs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en_sync,
    input  logic     bit_en,
    input  logic     sof,
    input  logic     eof,
    input  fcs_cfg_t cfg,
    input  logic     data_bit,
    output logic     crc_ok
);

    crc_t crc_q;
    logic ok_q;
    crc_t expect_res;

    assign expect_res = good_residue(cfg);

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= '0;
            ok_q  <= 1'b0;
        end else if (en_sync) begin
            if (sof) begin
                crc_q <= preset_val(cfg.preset_ones);
                ok_q  <= 1'b0;
            end else begin
                if (bit_en)
                    crc_q <= crc_step(crc_q, data_bit, cfg.poly);
                if (eof)
                    ok_q <= (crc_q == expect_res);
            end
        end
    end

    assign crc_ok = ok_q;

    AST_RX_OK_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(ok_q) |-> $past(eof && en_sync)); // R9
    AST_RX_OK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!eof && !sof) |=> $stable(ok_q)); // R9
    AST_RX_NO_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!bit_en && !sof) |=> $stable(crc_q)); // R10
    AST_RX_ASYNC_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en_sync |=> ($stable(crc_q) && $stable(ok_q))); // R11

endmodule

// File: rtl/hdlc_fcs_unit.sv
module hdlc_fcs_unit
    import fcs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sync_mode,
    input  logic sdlc_mode,
    input  logic preset_ones,
    input  logic poly_sel,
    input  logic bit_en,
    input  logic tx_sof,
    input  logic tx_bit,
    input  logic fcs_send,
    output logic tx_line,
    output logic tx_fcs_busy,
    input  logic rx_sof,
    input  logic rx_bit,
    input  logic rx_eof,
    output logic rx_crc_ok
);

    fcs_cfg_t cfg;

    always_comb begin
        cfg.sdlc        = sdlc_mode;
        cfg.preset_ones = preset_ones;
        cfg.poly        = poly_e'(poly_sel);
    end

    fcs_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .en_sync  (sync_mode),
        .bit_en   (bit_en),
        .sof      (tx_sof),
        .cfg      (cfg),
        .data_bit (tx_bit),
        .fcs_go   (fcs_send),
        .line_bit (tx_line),
        .fcs_busy (tx_fcs_busy)
    );

    fcs_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .en_sync  (sync_mode),
        .bit_en   (bit_en),
        .sof      (rx_sof),
        .eof      (rx_eof),
        .cfg      (cfg),
        .data_bit (rx_bit),
        .crc_ok   (rx_crc_ok)
    );

    AST_LINE_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        !tx_fcs_busy |-> (tx_line == tx_bit)); // R5

endmodule

// File: tb/hdlc_fcs_unit_bench.sv
module hdlc_fcs_unit_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_mode = 1'b1, sdlc_mode = 1'b0, preset_ones = 1'b0, poly_sel = 1'b0;
    logic bit_en = 1'b0, tx_sof = 1'b0, tx_bit = 1'b0, fcs_send = 1'b0;
    logic rx_sof = 1'b0, rx_bit = 1'b0, rx_eof = 1'b0;
    logic tx_line, tx_fcs_busy, rx_crc_ok;

    int total = 0;
    int bad = 0;
    logic [15:0] model;
    int unsigned lcg = 32'h1234_5678;

    always #10 clk = ~clk;

    hdlc_fcs_unit u_hdlc_fcs_unit (
        .clk(clk), .rst(rst), .sync_mode(sync_mode), .sdlc_mode(sdlc_mode),
        .preset_ones(preset_ones), .poly_sel(poly_sel), .bit_en(bit_en),
        .tx_sof(tx_sof), .tx_bit(tx_bit), .fcs_send(fcs_send),
        .tx_line(tx_line), .tx_fcs_busy(tx_fcs_busy), .rx_sof(rx_sof),
        .rx_bit(rx_bit), .rx_eof(rx_eof), .rx_crc_ok(rx_crc_ok)
    );

    function automatic logic [15:0] m_step(logic [15:0] c, logic d, logic ansi);
        logic fb;
        fb = c[0] ^ d;
        c = c >> 1;
        if (fb) c = c ^ (ansi ? 16'hA001 : 16'h8408);
        return c;
    endfunction

    function automatic logic next_rand();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return lcg[16];
    endfunction

    task automatic check(input logic cond, input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start(input logic ansi, input logic sdlc, input logic ones);
        poly_sel = ansi; sdlc_mode = sdlc; preset_ones = ones;
        tx_sof = 1'b1; rx_sof = 1'b1;
        @(negedge clk);
        tx_sof = 1'b0; rx_sof = 1'b0;
        model = ones ? 16'hFFFF : 16'h0000;
    endtask

    task automatic put_bit(input logic d, input logic flip_rx);
        tx_bit = d; rx_bit = d ^ flip_rx; bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        model = m_step(model, d, poly_sel);
    endtask

    task automatic gap();
        bit_en = 1'b0; tx_bit = next_rand(); rx_bit = next_rand();
        @(negedge clk);
    endtask

    task automatic fcs_out(input string req, output logic [15:0] got);
        logic [15:0] exp;
        exp = sdlc_mode ? ~model : model;
        fcs_send = 1'b1;
        @(negedge clk);
        fcs_send = 1'b0;
        check(tx_fcs_busy == 1'b1, "R5 busy rise", {15'b0, tx_fcs_busy}, 16'h1);
        for (int i = 0; i < 16; i++) begin
            got[i] = tx_line;
            rx_bit = exp[i]; tx_bit = next_rand(); bit_en = 1'b1;
            @(negedge clk);
        end
        bit_en = 1'b0;
        check(tx_fcs_busy == 1'b0, "R5 busy fall", {15'b0, tx_fcs_busy}, 16'h0);
        check(got == exp, req, got, exp);
    endtask

    task automatic finish_rx(input logic exp_ok, input string req);
        rx_eof = 1'b1;
        @(negedge clk);
        rx_eof = 1'b0;
        check(rx_crc_ok == exp_ok, req, {15'b0, rx_crc_ok}, {15'b0, exp_ok});
    endtask

    task automatic test_reset();
        logic [15:0] got;
        tx_bit = 1'b1;
        #1;
        check(rx_crc_ok == 1'b0 && tx_fcs_busy == 1'b0 && tx_line == 1'b1, "R1 reset outputs",
              {13'b0, rx_crc_ok, tx_fcs_busy, tx_line}, 16'h1);
        sdlc_mode = 1'b0; model = 16'h0000;
        fcs_out("R1 fcs after reset", got);
        finish_rx(1'b1, "R1 zero register passes");
    endtask

    task automatic test_preset();
        logic [15:0] got;
        start(1'b0, 1'b0, 1'b1);
        fcs_out("R2 preset ones ccitt", got);
        check(got == 16'hFFFF, "R2 literal ones", got, 16'hFFFF);
        start(1'b1, 1'b0, 1'b0);
        fcs_out("R2 preset zeros ansi", got);
        check(got == 16'h0000, "R2 literal zeros", got, 16'h0000);
        start(1'b1, 1'b1, 1'b1);
        fcs_out("R2 R6 preset ones ansi inverted", got);
        check(got == 16'h0000, "R6 inverted ones", got, 16'h0000);
    endtask

    task automatic test_known(input logic ansi, input logic sdlc, input logic ones,
                              input logic [15:0] lit, input string req);
        logic [15:0] got;
        start(ansi, sdlc, ones);
        for (int k = 0; k < 9; k++) begin
            logic [7:0] by;
            by = 8'h31 + 8'(k);
            for (int b = 0; b < 8; b++) put_bit(by[b], 1'b0);
        end
        fcs_out(req, got);
        check(got == lit, req, got, lit);
        finish_rx(1'b1, "R7 R8 known frame passes");
    endtask

    task automatic test_frame(input logic ansi, input logic sdlc, input logic ones, input int len,
                              input logic gaps, input int corrupt_at, input string req);
        logic [15:0] got;
        start(ansi, sdlc, ones);
        for (int i = 0; i < len; i++) begin
            put_bit(next_rand(), i == corrupt_at);
            if (gaps) gap();
        end
        fcs_out(req, got);
        finish_rx(corrupt_at < 0, req);
    endtask

    task automatic test_hold();
        test_frame(1'b0, 1'b1, 1'b1, 24, 1'b0, -1, "R8 frame before hold");
        for (int i = 0; i < 3; i++) put_bit(next_rand(), 1'b0);
        check(rx_crc_ok == 1'b1, "R9 ok holds without eof", {15'b0, rx_crc_ok}, 16'h1);
        rx_sof = 1'b1;
        @(negedge clk);
        rx_sof = 1'b0;
        check(rx_crc_ok == 1'b0, "R9 sof clears ok", {15'b0, rx_crc_ok}, 16'h0);
    endtask

    task automatic test_async();
        logic [15:0] got;
        test_frame(1'b1, 1'b0, 1'b0, 20, 1'b0, -1, "R7 frame before async");
        sync_mode = 1'b0;
        for (int i = 0; i < 5; i++) begin
            tx_bit = next_rand(); rx_bit = ~tx_bit; bit_en = 1'b1;
            @(negedge clk);
        end
        bit_en = 1'b0;
        rx_eof = 1'b1; rx_sof = 1'b1; tx_sof = 1'b1; fcs_send = 1'b1;
        @(negedge clk);
        rx_eof = 1'b0; rx_sof = 1'b0; tx_sof = 1'b0; fcs_send = 1'b0;
        check(rx_crc_ok == 1'b1, "R11 ok held in async", {15'b0, rx_crc_ok}, 16'h1);
        check(tx_fcs_busy == 1'b0, "R11 send ignored in async", {15'b0, tx_fcs_busy}, 16'h0);
        sync_mode = 1'b1;
        start(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 10; i++) put_bit(next_rand(), 1'b0);
        sync_mode = 1'b0;
        for (int i = 0; i < 6; i++) begin
            tx_bit = next_rand(); rx_bit = next_rand(); bit_en = 1'b1;
            @(negedge clk);
        end
        bit_en = 1'b0;
        sync_mode = 1'b1;
        for (int i = 0; i < 10; i++) put_bit(next_rand(), 1'b0);
        fcs_out("R11 fcs unaffected by async bits", got);
        finish_rx(1'b1, "R11 rx unaffected by async bits");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_preset();
        test_known(1'b0, 1'b0, 1'b1, 16'h6F91, "R3 ccitt known value");
        test_known(1'b0, 1'b1, 1'b1, 16'h906E, "R6 R8 ccitt inverted known value");
        test_known(1'b1, 1'b0, 1'b0, 16'hBB3D, "R4 ansi known value");
        test_frame(1'b0, 1'b0, 1'b0, 33, 1'b0, -1, "R3 R7 ccitt zero preset");
        test_frame(1'b1, 1'b1, 1'b0, 40, 1'b0, -1, "R4 R6 R8 ansi inverted");
        test_frame(1'b1, 1'b1, 1'b1, 17, 1'b0, -1, "R4 R8 ansi inverted ones");
        test_frame(1'b0, 1'b1, 1'b0, 30, 1'b1, -1, "R10 gaps ignored");
        test_frame(1'b0, 1'b1, 1'b1, 28, 1'b0, 11, "R8 corrupted frame fails");
        test_frame(1'b1, 1'b0, 1'b1, 28, 1'b0, 3, "R7 corrupted frame fails");
        test_hold();
        test_async();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule